// File: doc/BRIEF.md
# Serial-Ingress Cell Port Controller

This block is one input port of an input-queued cell switch. A serial bit stream enters most-significant bit first and is gathered into bytes. Every completed byte is written into a payload buffer. Cells are a fixed 53 bytes long, and the block finds cell boundaries by counting bytes. When a cell's last byte arrives, the cell is committed. At the same moment its 5-byte header is pushed into a separate header queue.

The header at the front of the queue carries a 12-bit routing field. That field indexes a programmable translation table, and the table returns the number of the destination output port. The controller turns the port number into a one-hot request toward a central scheduler and holds the request until a grant pulse comes back. It then streams the full cell onto the crossbar data path, one byte per clock.

Cells leave strictly in arrival order. If the buffer fills part-way through an incoming cell, that whole cell is discarded and a drop counter advances. Cells that were already stored are not affected.

Top module: `cellport_ingress`

## Requirements
- R1: Serial bits sampled while `ser_valid` is high are packed most-significant bit first into bytes, and each cell is delivered on `xbar_data` byte for byte in its arrival order.
- R2: The routing field is 12 bits: bits [3:0] of header byte 0 form its upper nibble and header byte 1 forms its lower eight bits. The request is the one-hot vector with bit N set, where N is the table entry for that field.
- R3: A table write (`tbl_we` high, `tbl_addr`, `tbl_port`) changes the destination used by cells that reach the front of the queue afterwards.
- R4: No request is raised until all 53 bytes of a cell have been stored.
- R5: The request stays unchanged until a grant arrives, even if the table is rewritten meanwhile. The request is low in the cycle after the grant.
- R6: After a grant that is sampled while a request is raised, `xbar_valid` is high for exactly 53 consecutive cycles starting with the next cycle.
- R7: Cells are requested and delivered in the order in which they arrived; a cell waiting for a grant holds back all later cells.
- R8: If a byte completes while the buffer is full, the whole cell is discarded and `drop_count` rises by exactly one. Cells stored earlier and cells arriving later are unaffected.
- R9: A grant that arrives while no request is raised has no effect.
- R10: After reset, `sched_req` is zero, `xbar_valid` is low and `drop_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_valid | input | 1 | Qualifies `ser_bit` in this cycle |
| ser_bit | input | 1 | Serial data, most significant bit of each byte first |
| tbl_we | input | 1 | Writes one translation-table entry |
| tbl_addr | input | 12 | Table entry index (routing field value) |
| tbl_port | input | 3 | Destination port stored in the entry |
| sched_req | output | 8 | One-hot request toward the scheduler |
| sched_grant | input | 1 | One-cycle grant pulse from the scheduler |
| xbar_valid | output | 1 | Cell byte present on `xbar_data` |
| xbar_data | output | 8 | Cell byte toward the crossbar |
| drop_count | output | 8 | Number of discarded cells, saturating |

## Verification
The bench targets the overflow case in which the buffer fills 22 bytes into the third cell. If the partial bytes were not rolled back, the later cell would come out with stale bytes in front of it, or a phantom request would appear. It also checks the stored request after a table rewrite, because a design that reads the table live would move its request away from the port the scheduler is about to grant. Other targets are a request raised one byte early, a burst of 52 or 54 valid cycles instead of 53, and a stray grant that starts a transfer from an empty queue. Random cells with random grant latencies check ordering and byte integrity across back-to-back traffic.

// File: rtl/cellport_pkg.sv
// Shared types for the serial-ingress cell port controller.
package cellport_pkg;

    // Egress sequencing: idle, holding a request, streaming a granted cell.
    typedef enum logic [1:0] {
        EG_IDLE = 2'd0,
        EG_WAIT = 2'd1,
        EG_SEND = 2'd2
    } eg_state_t;

endpackage

// File: rtl/cp_deser.sv
// Serial-to-byte converter.
// Shifts in one bit per cycle when bit_valid is high, most significant bit
// first, and presents a completed byte with a one-cycle byte_valid pulse.
// Assumes the bit stream is byte aligned from reset onward.
module cp_deser #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic         byte_valid,
    output logic [W-1:0] byte_out
);
    localparam int BW = $clog2(W);

    logic [W-1:0]  shreg;
    logic [BW-1:0] nbits;

    // Collect bits and emit a byte once W of them have arrived.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            nbits      <= '0;
            byte_valid <= 1'b0;
            byte_out   <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (bit_valid) begin
                shreg <= {shreg[W-2:0], bit_in};
                if (nbits == BW'(W-1)) begin
                    nbits      <= '0;
                    byte_valid <= 1'b1;
                    byte_out   <= {shreg[W-2:0], bit_in};
                end else begin
                    nbits <= nbits + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cp_fifo.sv
// Synchronous FIFO with a tentative write region.
// Writes are held back from the reader until commit is pulsed, so that the
// reader only ever sees whole units. rollback discards everything written
// since the last commit. A write and a commit in the same cycle commit
// together. Assumes commit and rollback are never high together.
module cp_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         commit,
    input  logic         rollback,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, cm_ptr, rd_ptr, wr_ptr_n;
    logic [CW-1:0] pend, avail;
    logic [CW:0]   used;
    logic          wr_fire, rd_fire;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy counts both committed and tentative entries.
    always_comb begin
        used     = {1'b0, pend} + {1'b0, avail};
        full     = (used == (CW+1)'(DEPTH));
        empty    = (avail == '0);
        wr_fire  = wr_en && !full && !rollback;
        rd_fire  = rd_en && !empty;
        wr_ptr_n = rollback ? cm_ptr : (wr_fire ? step(wr_ptr) : wr_ptr);
        rd_data  = mem[rd_ptr];
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (wr_fire) mem[wr_ptr] <= wr_data;
    end

    // Pointer and count bookkeeping for commit, rollback and reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            cm_ptr <= '0;
            rd_ptr <= '0;
            pend   <= '0;
            avail  <= '0;
        end else begin
            wr_ptr <= wr_ptr_n;
            if (commit) cm_ptr <= wr_ptr_n;
            if (rd_fire) rd_ptr <= step(rd_ptr);
            if (rollback || commit) pend <= '0;
            else                    pend <= pend + CW'(wr_fire);
            avail <= avail - CW'(rd_fire)
                   + (commit ? (pend + CW'(wr_fire)) : '0);
        end
    end

endmodule

// File: rtl/cp_lut.sv
// Programmable translation table: one write port, one asynchronous read.
// Entries are not reset; software must write every entry it relies on.
module cp_lut #(
    parameter int AW = 12,
    parameter int DW = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] tbl [2**AW];

    // Table update from the write port.
    always_ff @(posedge clk) begin
        if (we) tbl[waddr] <= wdata;
    end

    // Lookup of the queued routing field.
    assign rdata = tbl[raddr];

endmodule

// File: rtl/cellport_ingress.sv
// Serial-ingress cell port controller (top).
// Assembles fixed-size cells from a serial stream into a payload buffer,
// queues each committed cell's header separately, translates the header's
// routing field through a programmable table, requests the resulting output
// port and streams the cell out after a grant. A cell that meets a full
// buffer is discarded whole and counted. Assumes the serial stream starts
// on a cell boundary after reset and that HDR_BYTES >= 2.
module cellport_ingress
    import cellport_pkg::*;
#(
    parameter int CELL_BYTES = 53,
    parameter int HDR_BYTES  = 5,
    parameter int NUM_PORTS  = 8,
    parameter int ROUTE_W    = 12,
    parameter int BUF_DEPTH  = 128,
    parameter int DROP_W     = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ser_valid,
    input  logic                         ser_bit,
    input  logic                         tbl_we,
    input  logic [ROUTE_W-1:0]           tbl_addr,
    input  logic [$clog2(NUM_PORTS)-1:0] tbl_port,
    output logic [NUM_PORTS-1:0]         sched_req,
    input  logic                         sched_grant,
    output logic                         xbar_valid,
    output logic [7:0]                   xbar_data,
    output logic [DROP_W-1:0]            drop_count
);
    localparam int PORT_W    = $clog2(NUM_PORTS);
    localparam int HDR_W     = HDR_BYTES * 8;
    localparam int HDR_SLOTS = (BUF_DEPTH / CELL_BYTES > 0) ? BUF_DEPTH / CELL_BYTES : 1;
    localparam int IDX_W     = $clog2(CELL_BYTES);
    localparam int ROUTE_LSB = HDR_W - 4 - ROUTE_W;

    // ---------------- ingress ----------------
    logic              in_valid;
    logic [7:0]        in_byte;
    logic [IDX_W-1:0]  in_idx;
    logic              discarding;
    logic [HDR_W-1:0]  hdr_shift;
    logic              in_last;
    logic              pay_wr, pay_commit, pay_rollback, pay_full, pay_empty;
    logic              hdr_wr, hdr_full, hdr_empty, hdr_rd;
    logic [HDR_W-1:0]  hdr_head;
    logic              pay_rd;

    cp_deser #(.W(8)) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (ser_valid),
        .bit_in     (ser_bit),
        .byte_valid (in_valid),
        .byte_out   (in_byte)
    );

    // Decide per completed byte whether to store, commit or discard.
    always_comb begin
        in_last      = (in_idx == IDX_W'(CELL_BYTES - 1));
        pay_wr       = in_valid && !discarding && !pay_full;
        pay_rollback = in_valid && !discarding && pay_full;
        pay_commit   = pay_wr && in_last;
        hdr_wr       = pay_commit;
    end

    // Track position inside the cell, header bytes and the discard state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_idx     <= '0;
            discarding <= 1'b0;
            hdr_shift  <= '0;
            drop_count <= '0;
        end else if (in_valid) begin
            if (in_last) begin
                in_idx     <= '0;
                discarding <= 1'b0;
            end else begin
                in_idx <= in_idx + 1'b1;
                if (pay_rollback) discarding <= 1'b1;
            end
            if (pay_rollback && (drop_count != '1))
                drop_count <= drop_count + 1'b1;
            if (in_idx < IDX_W'(HDR_BYTES))
                hdr_shift <= {hdr_shift[HDR_W-9:0], in_byte};
        end
    end

    cp_fifo #(.W(8), .DEPTH(BUF_DEPTH)) u_payload (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pay_wr),
        .wr_data  (in_byte),
        .commit   (pay_commit),
        .rollback (pay_rollback),
        .rd_en    (pay_rd),
        .rd_data  (xbar_data),
        .full     (pay_full),
        .empty    (pay_empty)
    );

    cp_fifo #(.W(HDR_W), .DEPTH(HDR_SLOTS)) u_header (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (hdr_wr),
        .wr_data  (hdr_shift),
        .commit   (hdr_wr),
        .rollback (1'b0),
        .rd_en    (hdr_rd),
        .rd_data  (hdr_head),
        .full     (hdr_full),
        .empty    (hdr_empty)
    );

    // ---------------- translation ----------------
    logic [ROUTE_W-1:0] route_field;
    logic [PORT_W-1:0]  route_port;

    assign route_field = hdr_head[ROUTE_LSB +: ROUTE_W];

    cp_lut #(.AW(ROUTE_W), .DW(PORT_W)) u_lut (
        .clk   (clk),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (tbl_port),
        .raddr (route_field),
        .rdata (route_port)
    );

    // ---------------- egress ----------------
    eg_state_t         eg_state;
    logic [PORT_W-1:0] dest_q;
    logic [IDX_W-1:0]  out_idx;

    // Request, grant and streaming sequence; destination latched at request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eg_state <= EG_IDLE;
            dest_q   <= '0;
            out_idx  <= '0;
        end else begin
            unique case (eg_state)
                EG_IDLE: if (!hdr_empty) begin
                    eg_state <= EG_WAIT;
                    dest_q   <= route_port;
                end
                EG_WAIT: if (sched_grant) begin
                    eg_state <= EG_SEND;
                    out_idx  <= '0;
                end
                EG_SEND: begin
                    out_idx <= out_idx + 1'b1;
                    if (out_idx == IDX_W'(CELL_BYTES - 1)) eg_state <= EG_IDLE;
                end
                default: eg_state <= EG_IDLE;
            endcase
        end
    end

    // Header leaves at grant; payload drains one byte per streaming cycle.
    assign hdr_rd     = (eg_state == EG_WAIT) && sched_grant;
    assign pay_rd     = (eg_state == EG_SEND);
    assign xbar_valid = (eg_state == EG_SEND);

    // One-hot decode of the latched destination.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_req
        assign sched_req[p] = (eg_state == EG_WAIT) && (dest_q == PORT_W'(p));
    end

endmodule

// File: rtl/cellport_ingress_chk.sv
// Protocol checker for cellport_ingress, attached by bind below.
module cellport_ingress_chk #(
    parameter int NUM_PORTS = 8,
    parameter int DROP_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] sched_req,
    input logic                 sched_grant,
    input logic                 xbar_valid,
    input logic [DROP_W-1:0]    drop_count,
    input logic                 hdr_wr,
    input logic                 hdr_full
);
    // R2
    onehot_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sched_req));

    // R5
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_req != '0 && !sched_grant) |=> $stable(sched_req));

    // R6
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_req != '0 && sched_grant) |=> (xbar_valid && sched_req == '0));

    // R6
    no_req_while_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xbar_valid |-> (sched_req == '0));

    // R9
    stray_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sched_req == '0 && !xbar_valid && sched_grant) |=> !xbar_valid);

    // R8
    drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |->
        (drop_count == $past(drop_count) + 1'b1));

    // R4
    hdr_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_wr |-> !hdr_full);

endmodule

bind cellport_ingress cellport_ingress_chk #(
    .NUM_PORTS (NUM_PORTS),
    .DROP_W    (DROP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sched_req   (sched_req),
    .sched_grant (sched_grant),
    .xbar_valid  (xbar_valid),
    .drop_count  (drop_count),
    .hdr_wr      (hdr_wr),
    .hdr_full    (hdr_full)
);

// File: tb/sim_cellport_ingress.sv
module sim_cellport_ingress;
    localparam int CELL = 53;
    localparam int NCELL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_valid = 1'b0, ser_bit = 1'b0;
    logic        tbl_we = 1'b0;
    logic [11:0] tbl_addr = '0;
    logic [2:0]  tbl_port = '0;
    logic [7:0]  sched_req;
    logic        sched_grant = 1'b0;
    logic        xbar_valid;
    logic [7:0]  xbar_data;
    logic [7:0]  drop_count;

    int n_checks = 0, n_fail = 0, cycles = 0;
    logic [7:0] cells [NCELL][CELL];
    logic [2:0] lut_m [4096];

    cellport_ingress u0 (
        .clk(clk), .rst_n(rst_n), .ser_valid(ser_valid), .ser_bit(ser_bit),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_port(tbl_port),
        .sched_req(sched_req), .sched_grant(sched_grant),
        .xbar_valid(xbar_valid), .xbar_data(xbar_data), .drop_count(drop_count)
    );

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung, act=%0d exp<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] route_of(input int k);
        return {cells[k][0][3:0], cells[k][1]};
    endfunction

    task automatic make_cell(input int k, input logic [11:0] addr);
        cells[k][0] = {4'($urandom), addr[11:8]};
        cells[k][1] = addr[7:0];
        for (int i = 2; i < CELL; i++) cells[k][i] = 8'($urandom);
    endtask

    task automatic prog(input logic [11:0] a, input logic [2:0] p);
        tbl_we = 1'b1; tbl_addr = a; tbl_port = p;
        @(negedge clk);
        tbl_we = 1'b0;
        lut_m[a] = p;
    endtask

    // Send bytes first..last of cell k, MSB first, with optional idle gaps.
    task automatic send_bytes(input int k, input int first, input int last, input bit gaps);
        for (int b = first; b <= last; b++) begin
            for (int j = 7; j >= 0; j--) begin
                if (gaps && ($urandom % 4 == 0)) begin
                    ser_valid = 1'b0;
                    @(negedge clk);
                end
                ser_valid = 1'b1;
                ser_bit = cells[k][b][j];
                @(negedge clk);
            end
        end
        ser_valid = 1'b0;
    endtask

    // Wait for a request, check it, hold, grant, then check the 53-byte burst.
    task automatic serve(input int k, input int hold, input logic [7:0] exp_req, input string tag);
        int w = 0;
        bit held = 1;
        bit data_ok = 1;
        int bad_i = 0;
        logic [7:0] bad_v = '0;
        while (sched_req == 8'h00 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(sched_req == exp_req, {tag, " R2 request port"}, sched_req, exp_req);
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            if (sched_req != exp_req) held = 0;
        end
        chk(held, "R5 request held until grant", sched_req, exp_req);
        sched_grant = 1'b1;
        @(negedge clk);
        sched_grant = 1'b0;
        chk(sched_req == 8'h00, "R5 request dropped after grant", sched_req, 0);
        for (int i = 0; i < CELL; i++) begin
            if (data_ok && !(xbar_valid && xbar_data == cells[k][i])) begin
                data_ok = 0; bad_i = i; bad_v = xbar_data;
            end
            @(negedge clk);
        end
        chk(data_ok, {tag, " R1 R6 cell bytes"}, bad_v, cells[k][bad_i]);
        chk(!xbar_valid, "R6 burst length 53", xbar_valid, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(sched_req == 0, "R10 req after reset", sched_req, 0);
        chk(!xbar_valid, "R10 valid after reset", xbar_valid, 0);
        chk(drop_count == 0, "R10 drop count after reset", drop_count, 0);

        // R9 stray grant with nothing queued
        sched_grant = 1'b1;
        @(negedge clk);
        sched_grant = 1'b0;
        chk(!xbar_valid && sched_req == 0, "R9 stray grant ignored", xbar_valid, 0);
        repeat (3) @(negedge clk);
        chk(!xbar_valid, "R9 still idle", xbar_valid, 0);

        // R4 / R3 / R5 directed
        make_cell(0, 12'h5A3);
        prog(12'h5A3, 3'd6);
        send_bytes(0, 0, CELL - 2, 1'b0);
        repeat (6) @(negedge clk);
        chk(sched_req == 0, "R4 no request before last byte", sched_req, 0);
        send_bytes(0, CELL - 1, CELL - 1, 1'b0);
        repeat (4) @(negedge clk);
        chk(sched_req == 8'h40, "R4 request after full cell", sched_req, 8'h40);
        prog(12'h5A3, 3'd1);
        chk(sched_req == 8'h40, "R5 request stable across table rewrite", sched_req, 8'h40);
        serve(0, 2, 8'h40, "directed");
        make_cell(1, 12'h5A3);
        send_bytes(1, 0, CELL - 1, 1'b1);
        serve(1, 0, 8'h02, "R3 rewritten entry");

        // R7 random traffic in order
        for (int k = 2; k < 8; k++) begin
            make_cell(k, 12'($urandom));
            prog(route_of(k), 3'($urandom));
        end
        fork
            for (int k = 2; k < 8; k++) send_bytes(k, 0, CELL - 1, 1'b1);
            for (int k = 2; k < 8; k++)
                serve(k, $urandom % 6, 8'h01 << lut_m[route_of(k)], "R7 ordered");
        join

        // R8 overflow: A, B fit; C meets a full buffer 22 bytes in
        for (int k = 8; k < 12; k++) begin
            make_cell(k, 12'h100 + 12'(k));
            prog(route_of(k), 3'(k));
        end
        send_bytes(8, 0, CELL - 1, 1'b0);
        send_bytes(9, 0, CELL - 1, 1'b0);
        send_bytes(10, 0, CELL - 1, 1'b0);
        repeat (4) @(negedge clk);
        chk(drop_count == 1, "R8 one cell dropped", drop_count, 1);
        serve(8, 1, 8'h01 << lut_m[route_of(8)], "R8 first kept");
        serve(9, 1, 8'h01 << lut_m[route_of(9)], "R8 second kept");
        repeat (30) @(negedge clk);
        chk(sched_req == 0, "R8 dropped cell never requested", sched_req, 0);
        send_bytes(11, 0, CELL - 1, 1'b1);
        serve(11, 3, 8'h01 << lut_m[route_of(11)], "R8 later cell intact");
        chk(drop_count == 1, "R8 count unchanged", drop_count, 1);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule